// File: doc/BRIEF.md
# UART Automatic Power-Down Controller

This block sits beside a UART datapath and decides, cycle by cycle, whether the transmit path and the receive path may have their clocks or power gated. Each path has its own enable bit and its own small state machine. The path drops into power-down when its idle condition holds, and it comes back up on its own wake event. For transmit, the idle condition is that the holding buffer and the shift register are both empty, and the wake event is a write to the holding buffer. For receive, the idle condition is an empty FIFO with the receiver waiting for a start bit, and the wake event is any transition on the serial input pin.

A direct power-down input forces both outputs high whatever the automatic state is. When it drops, the automatic outputs show again. A ring-indicator change detector runs from the block's always-on clock whether or not either path is powered down. It sets a sticky interrupt flag that software clears with an acknowledge strobe. Both pins are synchronised through a chain of flops. Edge detection stays masked until that chain and the previous-sample flop hold valid data after reset.

Each path machine has three states. RUN is powered up and watching for idle. SLEEP is powered down. RECOVER is a one-cycle powered-up state entered on wake. The transitions are:
- ENTER: RUN to SLEEP, when the path is enabled, idle and not waking.
- WAKE: SLEEP to RECOVER, on the wake event.
- DISABLE: SLEEP or RECOVER to RUN, when the enable is low.
- SETTLE: RECOVER to RUN, always after one cycle.

Top module: `uart_autopd`

## Requirements
- R1: After reset, tx_powerdown, rx_powerdown and ri_irq are all 0.
- R2: With the transmit enable set, both transmit empty flags high and no buffer write, tx_powerdown rises after one clock edge (ENTER).
- R3: If either transmit empty flag is low, tx_powerdown stays 0.
- R4: A buffer write strobe seen while the transmit path is powered down clears tx_powerdown at the next clock edge (WAKE).
- R5: With the receive enable set, the FIFO empty and the receiver waiting for a start bit, rx_powerdown rises after one clock edge, provided no RXD change is being seen. It stays 0 while the receiver is not waiting for a start bit.
- R6: A level change on rxd_pin that is held clears rx_powerdown at the third clock edge after the change: two synchroniser edges, then the state register.
- R7: A wake event wins over the entry condition in the same cycle. After a wake the path stays powered up for at least two cycles (RECOVER, then RUN) before it can enter power-down again.
- R8: Clearing a path's enable drops that path's power-down output in the same cycle, with no clock edge needed, and returns the machine to RUN.
- R9: While direct_pd is 1, both power-down outputs are 1 regardless of enables and state. After it is released, the outputs follow the automatic logic.
- R10: A held level change on ri_pin sets ri_irq at the third clock edge after the change. This happens even while a path is powered down, and the change does not wake either path. Pin changes are ignored for the first three edges after reset.
- R11: ri_irq stays 1 until ri_ack is seen at a clock edge. If a new ring change and the acknowledge arrive at the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_apd_en | input | 1 | Enables automatic power-down of the transmit path |
| cfg_rx_apd_en | input | 1 | Enables automatic power-down of the receive path |
| direct_pd | input | 1 | Forces both paths into power-down |
| thr_empty | input | 1 | Transmit holding buffer is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| rx_fifo_empty | input | 1 | Receive FIFO is empty |
| rx_wait_start | input | 1 | Receiver is idle, waiting for a start bit |
| thr_wr | input | 1 | Write strobe to the transmit holding buffer |
| rxd_pin | input | 1 | Asynchronous serial receive pin |
| ri_pin | input | 1 | Asynchronous ring-indicator pin |
| ri_ack | input | 1 | Clears the ring-indicator interrupt flag |
| tx_powerdown | output | 1 | Transmit path power-down request |
| rx_powerdown | output | 1 | Receive path power-down request |
| ri_irq | output | 1 | Sticky ring-indicator change interrupt |

## Verification
The transmit entry is tried with each empty flag low on its own and then with both high. This separates an AND of the two flags from either flag alone. Wakes are driven both as a single strobe and as a strobe held across the recovery cycles, which separates wake priority from plain re-entry timing. The receive wake and the ring change are sampled at the second and third edges after the pin change, which pins the synchroniser depth exactly. The acknowledge is applied once alone and once on the same edge as a new ring change, which shows which of the two wins.

// File: rtl/uart_apd_pkg.sv
package uart_apd_pkg;

    typedef enum logic [1:0] {
        APD_RUN     = 2'b00,
        APD_SLEEP   = 2'b01,
        APD_RECOVER = 2'b10
    } apd_state_e;

    localparam int unsigned APD_SYNC_STAGES = 2;

endpackage

// File: rtl/uart_apd_sync_edge.sv
module uart_apd_sync_edge #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = uart_apd_pkg::APD_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_change
);
    localparam int unsigned PRIME_LIMIT = STAGES + 1;
    localparam int unsigned CNT_W       = $clog2(PRIME_LIMIT + 1);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             prev_q;
    logic [CNT_W-1:0]             prime_q;
    logic                         primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= pin_async;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else begin
                    chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            prime_q <= '0;
        end else begin
            prev_q <= chain_q[STAGES-1];
            if (!primed) begin
                prime_q <= prime_q + 1'b1;
            end
        end
    end

    assign primed = (prime_q == CNT_W'(PRIME_LIMIT));

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_edge
            assign pin_change[b] = primed && (chain_q[STAGES-1][b] ^ prev_q[b]);
        end
    endgenerate

endmodule

// File: rtl/uart_apd_path_fsm.sv
module uart_apd_path_fsm
    import uart_apd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic idle,
    input  logic wake,
    output logic auto_pd
);
    apd_state_e state_q;
    apd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            APD_RUN: begin
                if (enable && idle && !wake) begin
                    state_d = APD_SLEEP;
                end
            end
            APD_SLEEP: begin
                if (!enable) begin
                    state_d = APD_RUN;
                end else if (wake) begin
                    state_d = APD_RECOVER;
                end
            end
            APD_RECOVER: begin
                state_d = APD_RUN;
            end
            default: begin
                state_d = APD_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= APD_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        auto_pd = 1'b0;
        unique case (state_q)
            APD_SLEEP:   auto_pd = enable;
            APD_RUN:     auto_pd = 1'b0;
            APD_RECOVER: auto_pd = 1'b0;
            default:     auto_pd = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_apd_ri_flag.sv
module uart_apd_ri_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_autopd.sv
module uart_autopd #(
    parameter int unsigned SYNC_STAGES = uart_apd_pkg::APD_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_tx_apd_en,
    input  logic cfg_rx_apd_en,
    input  logic direct_pd,
    input  logic thr_empty,
    input  logic tsr_empty,
    input  logic rx_fifo_empty,
    input  logic rx_wait_start,
    input  logic thr_wr,
    input  logic rxd_pin,
    input  logic ri_pin,
    input  logic ri_ack,
    output logic tx_powerdown,
    output logic rx_powerdown,
    output logic ri_irq
);
    localparam int unsigned PIN_RXD = 0;
    localparam int unsigned PIN_RI  = 1;
    localparam int unsigned NPINS   = 2;

    logic [NPINS-1:0] pins_async;
    logic [NPINS-1:0] pins_change;
    logic             rxd_change;
    logic             ri_change;
    logic             tx_idle;
    logic             rx_idle;
    logic             tx_auto_pd;
    logic             rx_auto_pd;

    assign pins_async[PIN_RXD] = rxd_pin;
    assign pins_async[PIN_RI]  = ri_pin;

    uart_apd_sync_edge #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (pins_async),
        .pin_change (pins_change)
    );

    assign rxd_change = pins_change[PIN_RXD];
    assign ri_change  = pins_change[PIN_RI];

    assign tx_idle = thr_empty && tsr_empty;
    assign rx_idle = rx_fifo_empty && rx_wait_start;

    uart_apd_path_fsm u_tx_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_tx_apd_en),
        .idle    (tx_idle),
        .wake    (thr_wr),
        .auto_pd (tx_auto_pd)
    );

    uart_apd_path_fsm u_rx_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_rx_apd_en),
        .idle    (rx_idle),
        .wake    (rxd_change),
        .auto_pd (rx_auto_pd)
    );

    uart_apd_ri_flag u_ri (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (ri_change),
        .ack     (ri_ack),
        .flag    (ri_irq)
    );

    assign tx_powerdown = direct_pd || tx_auto_pd;
    assign rx_powerdown = direct_pd || rx_auto_pd;

endmodule

// File: rtl/uart_autopd_chk.sv
module uart_autopd_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_tx_apd_en,
    input logic cfg_rx_apd_en,
    input logic direct_pd,
    input logic thr_empty,
    input logic tsr_empty,
    input logic rx_fifo_empty,
    input logic rx_wait_start,
    input logic thr_wr,
    input logic ri_ack,
    input logic tx_powerdown,
    input logic rx_powerdown,
    input logic ri_irq,
    input logic tx_auto_pd,
    input logic rx_auto_pd,
    input logic rxd_change,
    input logic ri_change
);
    // R9
    direct_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        direct_pd |-> (tx_powerdown && rx_powerdown));

    // R8
    tx_en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_tx_apd_en && !direct_pd) |-> !tx_powerdown);

    // R8
    rx_en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rx_apd_en && !direct_pd) |-> !rx_powerdown);

    // R2
    tx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_auto_pd) |-> $past(thr_empty && tsr_empty && !thr_wr));

    // R4
    tx_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_auto_pd && thr_wr) |=> !tx_auto_pd);

    // R5
    rx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_auto_pd) |-> $past(rx_fifo_empty && rx_wait_start && !rxd_change));

    // R6
    rx_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_auto_pd && rxd_change) |=> !rx_auto_pd);

    // R7
    tx_no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_auto_pd) |=> !tx_auto_pd);

    // R7
    rx_no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_auto_pd) |=> !rx_auto_pd);

    // R10
    ri_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ri_change |=> ri_irq);

    // R11
    ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_irq && !ri_ack) |=> ri_irq);

    // R11
    ri_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_ack && !ri_change) |=> !ri_irq);

endmodule

bind uart_autopd uart_autopd_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_tx_apd_en (cfg_tx_apd_en),
    .cfg_rx_apd_en (cfg_rx_apd_en),
    .direct_pd     (direct_pd),
    .thr_empty     (thr_empty),
    .tsr_empty     (tsr_empty),
    .rx_fifo_empty (rx_fifo_empty),
    .rx_wait_start (rx_wait_start),
    .thr_wr        (thr_wr),
    .ri_ack        (ri_ack),
    .tx_powerdown  (tx_powerdown),
    .rx_powerdown  (rx_powerdown),
    .ri_irq        (ri_irq),
    .tx_auto_pd    (tx_auto_pd),
    .rx_auto_pd    (rx_auto_pd),
    .rxd_change    (rxd_change),
    .ri_change     (ri_change)
);

// File: tb/uart_autopd_tb.sv
module uart_autopd_tb;

    typedef struct {
        string tag;
        logic  tx;
        logic  rx;
        logic  irq;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_tx_apd_en = 1'b0;
    logic cfg_rx_apd_en = 1'b0;
    logic direct_pd = 1'b0;
    logic thr_empty = 1'b0;
    logic tsr_empty = 1'b0;
    logic rx_fifo_empty = 1'b0;
    logic rx_wait_start = 1'b0;
    logic thr_wr = 1'b0;
    logic rxd_pin = 1'b1;
    logic ri_pin = 1'b0;
    logic ri_ack = 1'b0;
    logic tx_powerdown;
    logic rx_powerdown;
    logic ri_irq;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    uart_autopd u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_tx_apd_en (cfg_tx_apd_en),
        .cfg_rx_apd_en (cfg_rx_apd_en),
        .direct_pd     (direct_pd),
        .thr_empty     (thr_empty),
        .tsr_empty     (tsr_empty),
        .rx_fifo_empty (rx_fifo_empty),
        .rx_wait_start (rx_wait_start),
        .thr_wr        (thr_wr),
        .rxd_pin       (rxd_pin),
        .ri_pin        (ri_pin),
        .ri_ack        (ri_ack),
        .tx_powerdown  (tx_powerdown),
        .rx_powerdown  (rx_powerdown),
        .ri_irq        (ri_irq)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic tx, input logic rx, input logic irq);
        exp_t e;
        e.tag = tag;
        e.tx  = tx;
        e.rx  = rx;
        e.irq = irq;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (tx_powerdown !== e.tx || rx_powerdown !== e.rx || ri_irq !== e.irq) begin
                errors++;
                $display("FAIL %s: tx/rx/irq actual %b%b%b expected %b%b%b",
                         e.tag, tx_powerdown, rx_powerdown, ri_irq, e.tx, e.rx, e.irq);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(1);
        expect_out("R1 reset", 0, 0, 0);
        tick(4);
        expect_out("R10 no startup edge", 0, 0, 0);

        cfg_tx_apd_en = 1'b1;
        thr_empty = 1'b1; tsr_empty = 1'b0;
        tick(3);
        expect_out("R3 shift reg busy", 0, 0, 0);
        thr_empty = 1'b0; tsr_empty = 1'b1;
        tick(3);
        expect_out("R3 holding buf busy", 0, 0, 0);

        thr_empty = 1'b1;
        tick(1);
        expect_out("R2 tx enter", 1, 0, 0);

        thr_wr = 1'b1;
        tick(1);
        thr_wr = 1'b0;
        expect_out("R4 tx wake", 0, 0, 0);
        tick(1);
        expect_out("R7 tx recover", 0, 0, 0);
        tick(1);
        expect_out("R7 tx reenter", 1, 0, 0);

        thr_wr = 1'b1;
        tick(3);
        expect_out("R7 wake priority", 0, 0, 0);
        thr_wr = 1'b0;
        tick(1);
        expect_out("R7 reenter after write", 1, 0, 0);

        tick(1);
        cfg_tx_apd_en = 1'b0;
        expect_out("R8 disable same cycle", 0, 0, 0);
        tick(1);
        expect_out("R8 disabled", 0, 0, 0);
        cfg_tx_apd_en = 1'b1;
        tick(1);
        expect_out("R8 reenable", 1, 0, 0);

        cfg_rx_apd_en = 1'b1;
        rx_fifo_empty = 1'b1; rx_wait_start = 1'b0;
        tick(3);
        expect_out("R5 receiving", 1, 0, 0);
        rx_wait_start = 1'b1;
        tick(1);
        expect_out("R5 rx enter", 1, 1, 0);

        rxd_pin = 1'b0;
        tick(2);
        expect_out("R6 still synchronising", 1, 1, 0);
        tick(1);
        expect_out("R6 rx wake", 1, 0, 0);
        tick(1);
        expect_out("R7 rx recover", 1, 0, 0);
        tick(1);
        expect_out("R7 rx reenter", 1, 1, 0);

        tick(1);
        cfg_tx_apd_en = 1'b0;
        direct_pd = 1'b1;
        expect_out("R9 direct forces", 1, 1, 0);
        tick(1);
        expect_out("R9 direct held", 1, 1, 0);
        direct_pd = 1'b0;
        tick(1);
        expect_out("R9 release", 0, 1, 0);

        ri_pin = 1'b1;
        tick(2);
        expect_out("R10 ri synchronising", 0, 1, 0);
        tick(1);
        expect_out("R10 ri set while rx down", 0, 1, 1);

        tick(3);
        expect_out("R11 sticky", 0, 1, 1);
        ri_ack = 1'b1;
        tick(1);
        ri_ack = 1'b0;
        expect_out("R11 ack clears", 0, 1, 0);

        ri_pin = 1'b0;
        tick(2);
        ri_ack = 1'b1;
        tick(1);
        ri_ack = 1'b0;
        expect_out("R11 set beats ack", 0, 1, 1);
        ri_ack = 1'b1;
        tick(1);
        ri_ack = 1'b0;
        expect_out("R11 second ack", 0, 1, 0);

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule